// File: doc/BRIEF.md
# Paired-Page Translation Lookaside Buffer

This block is a fully associative address translation cache with sixteen entries. Each entry holds one tag for a virtual region that spans two pages. The region maps onto two physical pages that are chosen separately. Each entry has its own page size, from 4 KB up to 256 MB in steps of four. It also carries an 8-bit address-space identifier, and a global flag can override that identifier.

The lookup port is combinational. It takes a virtual address, the current identifier and a store flag. In the same cycle it returns the physical address and the cache attribute, along with exactly one of hit, miss, invalid fault or modify fault. A write port loads a whole entry at an index on a clock edge. A read port shows the entry stored at a second index. A probe port searches with its own address and identifier and returns the index of the entry that matches, or a failure flag.

Top module: `pptlb`

## Requirements
- R1: After reset no entry is loaded. Every lookup misses and every probe fails, until an entry is written.
- R2: While wr_en is high, a rising clock edge loads the entry at wr_idx. The read port shows the stored VPN2, size code and identifier at rd_idx. The entry's single global flag is wr_g0 AND wr_g1, and it reads back on both rd_g0 and rd_g1.
- R3: The size code c gives a page of 4 KB times 4^c. Codes above 8 act as 8. Let s = 12 + 2*min(c,8). An entry's tag matches when VA bits 31 down to s+1 equal the same bits of {VPN2, 13'b0}. The identifier must also equal lk_asid.
- R4: VA bit s picks the half: 0 picks half 0 and 1 picks half 1.
- R5: The physical address takes bits 31..s from {PFN, 12'b0} and bits s-1..0 from the virtual address.
- R6: An entry whose global flag is set matches under any identifier.
- R7: If the matched half's valid flag is 0, lk_inval is set and lk_hit is clear.
- R8: If a store matches a valid half whose dirty flag is 0, lk_mod is set and lk_hit is clear. A load to that half hits.
- R9: When no entry matches, lk_miss is 1. lk_hit, lk_inval, lk_mod, lk_pa and lk_cattr are all 0. On any match, lk_pa and lk_cattr come from the selected half, whether or not a fault is raised.
- R10: When several entries match, the one with the lowest index wins, for both lookup and probe.
- R11: A probe returns the index of the matching entry with pr_fail at 0. When nothing matches, it returns pr_fail at 1 and pr_idx at 0.
- R12: Writing an index that is already loaded replaces the old entry completely. The old translation then misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Load entry at wr_idx |
| wr_idx | input | 4 | Entry index to load |
| wr_vpn2 | input | 19 | Virtual page-pair number, VA[31:13] |
| wr_size | input | 4 | Page size code |
| wr_asid | input | 8 | Address-space identifier |
| wr_g0 | input | 1 | Global flag written through half 0 |
| wr_g1 | input | 1 | Global flag written through half 1 |
| wr_pfn0 | input | 20 | Frame number, half 0 |
| wr_c0 | input | 3 | Cache attribute, half 0 |
| wr_d0 | input | 1 | Dirty (writable), half 0 |
| wr_v0 | input | 1 | Valid, half 0 |
| wr_pfn1 | input | 20 | Frame number, half 1 |
| wr_c1 | input | 3 | Cache attribute, half 1 |
| wr_d1 | input | 1 | Dirty (writable), half 1 |
| wr_v1 | input | 1 | Valid, half 1 |
| rd_idx | input | 4 | Entry index to read |
| rd_vpn2 | output | 19 | Stored VPN2 |
| rd_size | output | 4 | Stored size code |
| rd_asid | output | 8 | Stored identifier |
| rd_g0 | output | 1 | Global flag seen through half 0 |
| rd_g1 | output | 1 | Global flag seen through half 1 |
| lk_va | input | 32 | Lookup virtual address |
| lk_asid | input | 8 | Current identifier |
| lk_store | input | 1 | Access is a store |
| lk_hit | output | 1 | Usable translation |
| lk_miss | output | 1 | No entry matched |
| lk_inval | output | 1 | Matched half not valid |
| lk_mod | output | 1 | Store to a clean half |
| lk_pa | output | 32 | Physical address |
| lk_cattr | output | 3 | Cache attribute |
| pr_va | input | 32 | Probe virtual address |
| pr_asid | input | 8 | Probe identifier |
| pr_idx | output | 4 | Matching entry index |
| pr_fail | output | 1 | Probe found no match |

## Verification
Directed cases set up global and non-global entries at small and large page sizes. A size code above 8 checks the clamp. Addresses on either side of the half-select bit show whether the half is chosen by size. Identifiers that differ by one show whether the identifier compare and the global bypass work. Duplicate tags at two indices test the priority rule. Rewriting an index tests replacement. In the random rounds the tags come from a small pool and the size codes include values above 8. The lookup addresses have random low bits and an occasional flipped high bit, so the mask edge sees both hits and near-misses. Every lookup and probe is compared with a model that tests the tag with shifts instead of masks.

// File: rtl/pptlb_pkg.sv
package pptlb_pkg;
  parameter int VA_W       = 32;
  parameter int PAGE_SHIFT = 12;
  parameter int ASID_W     = 8;
  parameter int SZ_W       = 4;
  parameter int CA_W       = 3;
  parameter int MAX_CODE   = 8;
  localparam int PFN_W     = VA_W - PAGE_SHIFT;
  localparam int VPN2_W    = VA_W - PAGE_SHIFT - 1;

  typedef struct packed {
    logic [PFN_W-1:0] pfn;
    logic [CA_W-1:0]  cattr;
    logic             dirty;
    logic             valid;
  } half_t;

  typedef struct packed {
    logic              used;
    logic [VPN2_W-1:0] vpn2;
    logic [SZ_W-1:0]   size;
    logic [ASID_W-1:0] asid;
    logic              glob;
    half_t             h0;
    half_t             h1;
  } ent_t;

  // bit position that picks the half; page offset lies below it
  function automatic int half_pos(input logic [SZ_W-1:0] code);
    int c;
    c = (int'(code) > MAX_CODE) ? MAX_CODE : int'(code);
    return PAGE_SHIFT + 2 * c;
  endfunction

  function automatic logic [VA_W-1:0] low_mask(input int pos);
    logic [VA_W-1:0] m;
    for (int i = 0; i < VA_W; i++) m[i] = (i < pos);
    return m;
  endfunction

  function automatic logic tag_eq(input logic [VPN2_W-1:0] vpn2,
                                  input logic [VA_W-1:0] va,
                                  input logic [SZ_W-1:0] code);
    logic [VA_W-1:0] diff;
    logic eq;
    int pos;
    pos  = half_pos(code);
    diff = {vpn2, {(PAGE_SHIFT + 1){1'b0}}} ^ va;
    eq   = 1'b1;
    for (int i = 0; i < VA_W; i++)
      if (i > pos && diff[i]) eq = 1'b0;
    return eq;
  endfunction

  function automatic logic [VA_W-1:0] form_pa(input logic [PFN_W-1:0] pfn,
                                              input logic [VA_W-1:0] va,
                                              input logic [SZ_W-1:0] code);
    logic [VA_W-1:0] lm;
    lm = low_mask(half_pos(code));
    return ({pfn, {PAGE_SHIFT{1'b0}}} & ~lm) | (va & lm);
  endfunction
endpackage

// File: rtl/pptlb_way.sv
module pptlb_way
  import pptlb_pkg::*;
(
  input  ent_t              ent,
  input  logic [VA_W-1:0]   va,
  input  logic [ASID_W-1:0] asid,
  output logic              match
);
  logic tag_ok;
  logic asid_ok;

  assign tag_ok  = tag_eq(ent.vpn2, va, ent.size);
  assign asid_ok = ent.glob || (ent.asid == asid);
  assign match   = ent.used && tag_ok && asid_ok;
endmodule

// File: rtl/pptlb_pick.sv
module pptlb_pick #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic [N-1:0]  req,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx = IW'(i);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pptlb_form.sv
module pptlb_form
  import pptlb_pkg::*;
(
  input  ent_t            ent,
  input  logic            found,
  input  logic [VA_W-1:0] va,
  input  logic            store,
  output logic            hit,
  output logic            miss,
  output logic            inval,
  output logic            mod,
  output logic [VA_W-1:0] pa,
  output logic [CA_W-1:0] cattr
);
  half_t h;
  int    pos;

  always_comb begin
    pos   = half_pos(ent.size);
    h     = va[pos] ? ent.h1 : ent.h0;
    hit   = 1'b0;
    miss  = 1'b0;
    inval = 1'b0;
    mod   = 1'b0;
    pa    = '0;
    cattr = '0;
    if (!found) begin
      miss = 1'b1;
    end else begin
      pa    = form_pa(h.pfn, va, ent.size);
      cattr = h.cattr;
      if (!h.valid)                inval = 1'b1;
      else if (store && !h.dirty)  mod   = 1'b1;
      else                         hit   = 1'b1;
    end
  end
endmodule

// File: rtl/pptlb.sv
module pptlb
  import pptlb_pkg::*;
#(
  parameter int N_ENT = 16,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VPN2_W-1:0] wr_vpn2,
  input  logic [SZ_W-1:0]   wr_size,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_g0,
  input  logic              wr_g1,
  input  logic [PFN_W-1:0]  wr_pfn0,
  input  logic [CA_W-1:0]   wr_c0,
  input  logic              wr_d0,
  input  logic              wr_v0,
  input  logic [PFN_W-1:0]  wr_pfn1,
  input  logic [CA_W-1:0]   wr_c1,
  input  logic              wr_d1,
  input  logic              wr_v1,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [VPN2_W-1:0] rd_vpn2,
  output logic [SZ_W-1:0]   rd_size,
  output logic [ASID_W-1:0] rd_asid,
  output logic              rd_g0,
  output logic              rd_g1,
  input  logic [VA_W-1:0]   lk_va,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              lk_store,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic              lk_inval,
  output logic              lk_mod,
  output logic [VA_W-1:0]   lk_pa,
  output logic [CA_W-1:0]   lk_cattr,
  input  logic [VA_W-1:0]   pr_va,
  input  logic [ASID_W-1:0] pr_asid,
  output logic [IDX_W-1:0]  pr_idx,
  output logic              pr_fail
);
  ent_t             tbl [N_ENT];
  ent_t             new_ent;
  ent_t             lk_ent;
  ent_t             rd_ent;
  logic [N_ENT-1:0] lk_match;
  logic [N_ENT-1:0] pr_match;
  logic [N_ENT-1:0] loaded;
  logic [IDX_W-1:0] lk_sel;
  logic             lk_found;
  logic             pr_found;

  always_comb begin
    new_ent.used     = 1'b1;
    new_ent.vpn2     = wr_vpn2;
    new_ent.size     = wr_size;
    new_ent.asid     = wr_asid;
    new_ent.glob     = wr_g0 & wr_g1;
    new_ent.h0.pfn   = wr_pfn0;
    new_ent.h0.cattr = wr_c0;
    new_ent.h0.dirty = wr_d0;
    new_ent.h0.valid = wr_v0;
    new_ent.h1.pfn   = wr_pfn1;
    new_ent.h1.cattr = wr_c1;
    new_ent.h1.dirty = wr_d1;
    new_ent.h1.valid = wr_v1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_ENT; i++) tbl[i] <= '0;
    end else if (wr_en) begin
      tbl[wr_idx] <= new_ent;
    end
  end

  for (genvar g = 0; g < N_ENT; g++) begin : g_way
    assign loaded[g] = tbl[g].used;
    pptlb_way u_lk (.ent(tbl[g]), .va(lk_va), .asid(lk_asid), .match(lk_match[g]));
    pptlb_way u_pr (.ent(tbl[g]), .va(pr_va), .asid(pr_asid), .match(pr_match[g]));
  end

  pptlb_pick #(.N(N_ENT), .IW(IDX_W)) u_lk_pick (
    .req(lk_match), .idx(lk_sel), .any(lk_found));
  pptlb_pick #(.N(N_ENT), .IW(IDX_W)) u_pr_pick (
    .req(pr_match), .idx(pr_idx), .any(pr_found));

  assign pr_fail = !pr_found;
  assign lk_ent  = tbl[lk_sel];

  pptlb_form u_form (
    .ent(lk_ent), .found(lk_found), .va(lk_va), .store(lk_store),
    .hit(lk_hit), .miss(lk_miss), .inval(lk_inval), .mod(lk_mod),
    .pa(lk_pa), .cattr(lk_cattr));

  assign rd_ent  = tbl[rd_idx];
  assign rd_vpn2 = rd_ent.vpn2;
  assign rd_size = rd_ent.size;
  assign rd_asid = rd_ent.asid;
  assign rd_g0   = rd_ent.glob;
  assign rd_g1   = rd_ent.glob;
endmodule

// File: rtl/pptlb_chk.sv
module pptlb_chk
  import pptlb_pkg::*;
#(
  parameter int N_ENT = 16,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_idx,
  input logic [N_ENT-1:0] loaded,
  input logic [VA_W-1:0]  lk_va,
  input logic             lk_store,
  input logic             lk_hit,
  input logic             lk_miss,
  input logic             lk_inval,
  input logic             lk_mod,
  input logic [VA_W-1:0]  lk_pa,
  input logic [CA_W-1:0]  lk_cattr,
  input logic             pr_fail,
  input logic [IDX_W-1:0] pr_idx,
  input logic             rd_g0,
  input logic             rd_g1
);
  // R1
  empty_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> loaded == '0);

  // R1
  empty_misses_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loaded == '0 |-> lk_miss && pr_fail);

  // R2
  write_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> loaded[$past(wr_idx)]);

  // R2
  global_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_g0 == rd_g1);

  // R5
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_pa[PAGE_SHIFT-1:0] == lk_va[PAGE_SHIFT-1:0]);

  // R8
  mod_on_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_mod |-> lk_store);

  // R9
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_miss |-> lk_pa == '0 && lk_cattr == '0);

  // R7
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({lk_hit, lk_miss, lk_inval, lk_mod}) == 1);

  // R11
  fail_idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pr_fail |-> pr_idx == '0);
endmodule

bind pptlb pptlb_chk #(.N_ENT(N_ENT)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .loaded(loaded),
  .lk_va(lk_va), .lk_store(lk_store), .lk_hit(lk_hit), .lk_miss(lk_miss),
  .lk_inval(lk_inval), .lk_mod(lk_mod), .lk_pa(lk_pa), .lk_cattr(lk_cattr),
  .pr_fail(pr_fail), .pr_idx(pr_idx), .rd_g0(rd_g0), .rd_g1(rd_g1));

// File: tb/test_pptlb.sv
module test_pptlb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [18:0] wr_vpn2 = '0;
  logic [3:0]  wr_size = '0;
  logic [7:0]  wr_asid = '0;
  logic        wr_g0 = 1'b0, wr_g1 = 1'b0;
  logic [19:0] wr_pfn0 = '0, wr_pfn1 = '0;
  logic [2:0]  wr_c0 = '0, wr_c1 = '0;
  logic        wr_d0 = 1'b0, wr_v0 = 1'b0, wr_d1 = 1'b0, wr_v1 = 1'b0;
  logic [3:0]  rd_idx = '0;
  logic [18:0] rd_vpn2;
  logic [3:0]  rd_size;
  logic [7:0]  rd_asid;
  logic        rd_g0, rd_g1;
  logic [31:0] lk_va = '0;
  logic [7:0]  lk_asid = '0;
  logic        lk_store = 1'b0;
  logic        lk_hit, lk_miss, lk_inval, lk_mod;
  logic [31:0] lk_pa;
  logic [2:0]  lk_cattr;
  logic [31:0] pr_va = '0;
  logic [7:0]  pr_asid = '0;
  logic [3:0]  pr_idx;
  logic        pr_fail;

  pptlb i_pptlb (.*);

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [18:0] m_vpn2 [16];
  logic [3:0]  m_size [16];
  logic [7:0]  m_asid [16];
  logic        m_g [16];
  logic        m_used [16];
  logic [24:0] m_h0 [16];
  logic [24:0] m_h1 [16];

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int shift_of(input logic [3:0] c);
    return 12 + 2 * ((c > 4'd8) ? 8 : int'(c));
  endfunction

  function automatic int find(input logic [31:0] va, input logic [7:0] asid);
    for (int e = 0; e < 16; e++) begin
      int sh;
      sh = shift_of(m_size[e]);
      if (m_used[e] && ((va >> (sh + 1)) == ({m_vpn2[e], 13'b0} >> (sh + 1)))
          && (m_g[e] || m_asid[e] == asid))
        return e;
    end
    return -1;
  endfunction

  // {hit, miss, inval, mod, cattr, pa}
  function automatic logic [38:0] model(input logic [31:0] va, input logic [7:0] asid,
                                        input logic st);
    int e, sh;
    logic [24:0] h;
    logic [63:0] lm, pa;
    e = find(va, asid);
    if (e < 0) return {4'b0100, 35'b0};
    sh = shift_of(m_size[e]);
    h  = va[sh] ? m_h1[e] : m_h0[e];
    lm = (64'd1 << sh) - 64'd1;
    pa = ({44'b0, h[24:5]} << 12) & ~lm | ({32'b0, va} & lm);
    if (!h[0])           return {4'b0010, h[4:2], pa[31:0]};
    else if (st && !h[1]) return {4'b0001, h[4:2], pa[31:0]};
    else                 return {4'b1000, h[4:2], pa[31:0]};
  endfunction

  task automatic set_ent(input int idx, input logic [18:0] vpn2, input logic [3:0] sz,
                         input logic [7:0] asid, input logic g0, input logic g1,
                         input logic [24:0] h0, input logic [24:0] h1);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'(idx); wr_vpn2 = vpn2; wr_size = sz; wr_asid = asid;
    wr_g0 = g0; wr_g1 = g1;
    {wr_pfn0, wr_c0, wr_d0, wr_v0} = h0;
    {wr_pfn1, wr_c1, wr_d1, wr_v1} = h1;
    @(negedge clk);
    wr_en = 1'b0;
    m_vpn2[idx] = vpn2; m_size[idx] = sz; m_asid[idx] = asid; m_g[idx] = g0 & g1;
    m_h0[idx] = h0; m_h1[idx] = h1; m_used[idx] = 1'b1;
  endtask

  task automatic look(input string req, input logic [31:0] va, input logic [7:0] asid,
                      input logic st);
    int e;
    lk_va = va; lk_asid = asid; lk_store = st;
    pr_va = va; pr_asid = asid;
    #2;
    check(req, {25'b0, lk_hit, lk_miss, lk_inval, lk_mod, lk_cattr, lk_pa},
          {25'b0, model(va, asid, st)});
    e = find(va, asid);
    check({req, " probe R11"}, {59'b0, pr_fail, pr_idx},
          {59'b0, (e < 0), (e < 0) ? 4'd0 : 4'(e)});
    @(negedge clk);
  endtask

  task automatic readback(input string req, input int idx);
    rd_idx = 4'(idx);
    #2;
    check(req, {30'b0, rd_vpn2, rd_size, rd_asid, rd_g0, rd_g1},
          {30'b0, m_vpn2[idx], m_size[idx], m_asid[idx], m_g[idx], m_g[idx]});
  endtask

  function automatic logic [24:0] hv(input logic [19:0] pfn, input logic [2:0] c,
                                     input logic d, input logic v);
    return {pfn, c, d, v};
  endfunction

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    logic [18:0] pool [4];
    seed = $urandom(32'd2024);
    for (int i = 0; i < 16; i++) m_used[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: empty after reset
    look("R1 reset miss", 32'h0000_0000, 8'd0, 1'b0);
    look("R1 reset miss 2", 32'h1234_5678, 8'd5, 1'b1);

    // R2: write, readback, global AND
    set_ent(3, 19'h00201, 4'd0, 8'd5, 1'b1, 1'b0,
            hv(20'hAAAAA, 3'd2, 1'b1, 1'b1), hv(20'h55555, 3'd3, 1'b1, 1'b1));
    readback("R2 readback g split", 3);
    look("R4 half0", 32'h0040_2ABC, 8'd5, 1'b0);
    look("R4 half1", 32'h0040_3ABC, 8'd5, 1'b0);
    look("R3 asid mismatch", 32'h0040_2ABC, 8'd6, 1'b0);
    look("R3 tag mismatch", 32'h0040_6ABC, 8'd5, 1'b0);

    // R6, R5: global, 64 KB pages
    set_ent(4, 19'h00400, 4'd2, 8'd9, 1'b1, 1'b1,
            hv(20'h12345, 3'd1, 1'b1, 1'b1), hv(20'hFEDCB, 3'd7, 1'b1, 1'b1));
    readback("R2 readback global", 4);
    look("R6 global other asid", 32'h0081_2345, 8'd77, 1'b0);
    look("R5 low bits from va", 32'h0080_F00F, 8'd1, 1'b1);

    // R7, R8
    set_ent(5, 19'h08000, 4'd0, 8'd5, 1'b0, 1'b0,
            hv(20'h00011, 3'd4, 1'b1, 1'b0), hv(20'h00022, 3'd5, 1'b0, 1'b1));
    look("R7 invalid half", 32'h1000_0010, 8'd5, 1'b0);
    look("R8 store clean", 32'h1000_1010, 8'd5, 1'b1);
    look("R8 load clean", 32'h1000_1010, 8'd5, 1'b0);
    look("R9 miss outputs", 32'h2000_0000, 8'd5, 1'b1);

    // R10: duplicates
    set_ent(7, 19'h10000, 4'd1, 8'd3, 1'b0, 1'b0,
            hv(20'h00700, 3'd1, 1'b1, 1'b1), hv(20'h00701, 3'd1, 1'b1, 1'b1));
    set_ent(2, 19'h10000, 4'd1, 8'd3, 1'b0, 1'b0,
            hv(20'h00200, 3'd6, 1'b1, 1'b1), hv(20'h00201, 3'd6, 1'b1, 1'b1));
    look("R10 lowest index", 32'h2000_1234, 8'd3, 1'b0);

    // R3: size code above 8 clamps
    set_ent(9, 19'h20000, 4'd15, 8'd1, 1'b0, 1'b0,
            hv(20'h30000, 3'd2, 1'b1, 1'b1), hv(20'hC0000, 3'd3, 1'b1, 1'b1));
    readback("R2 raw size", 9);
    look("R3 clamp half0", 32'h4ABC_DEF0, 8'd1, 1'b0);
    look("R3 clamp half1", 32'h5ABC_DEF0, 8'd1, 1'b0);
    look("R3 clamp outside", 32'h6000_0000, 8'd1, 1'b0);

    // R12: replacement
    set_ent(3, 19'h00300, 4'd0, 8'd5, 1'b0, 1'b0,
            hv(20'h00123, 3'd0, 1'b1, 1'b1), hv(20'h00124, 3'd0, 1'b1, 1'b1));
    look("R12 old gone", 32'h0040_2ABC, 8'd5, 1'b0);
    look("R12 new live", 32'h0060_0ABC, 8'd5, 1'b0);
    readback("R12 readback", 3);

    // random rounds
    for (int r = 0; r < 4; r++) begin
      for (int k = 0; k < 4; k++) pool[k] = 19'($urandom);
      for (int i = 0; i < 16; i++) begin
        logic [18:0] vp;
        vp = pool[$urandom % 4];
        if ($urandom % 2 == 1) vp = vp ^ 19'($urandom % 64);
        set_ent(i, vp, 4'($urandom % 11), ($urandom % 2 == 1) ? 8'd5 : 8'd9,
                1'($urandom), 1'($urandom), 25'($urandom), 25'($urandom));
      end
      for (int n = 0; n < 150; n++) begin
        int e;
        logic [31:0] va;
        logic [7:0] as;
        e  = int'($urandom % 16);
        va = {m_vpn2[e], 13'b0} | ($urandom & 32'h0000_1FFF);
        if ($urandom % 3 == 0) va = va ^ (32'd1 << ($urandom % 32));
        if ($urandom % 4 == 0) va = va | ($urandom & 32'h0FFF_FFFF);
        case ($urandom % 3)
          0: as = 8'd5;
          1: as = 8'd9;
          default: as = 8'd7;
        endcase
        look("R3 R4 R5 R6 R7 R8 R9 R10 random", va, as, 1'($urandom));
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule